// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a processor core. It collects five interrupt sources and presents the most urgent one as a single request with a fixed 16-bit restart address. The most urgent source is non-maskable. The next three are maskable and vectored: one is latched on its rising edge, and two follow their input level. The last is a general request that carries no vector of its own. When that general source wins, the core must fetch its instruction from outside.

Software controls the block through a mask-write byte and two strobes. One strobe sets the global interrupt-enable flag and the other clears it. A status byte reports the serial input, the pending state of the three vectored sources, the enable flag and the current masks. The same mask-write byte also carries a one-bit serial output latch and a command that clears the edge latch.

When the core acknowledges, the winning latched source is cleared and the enable flag drops. The enable flag then stays low until software raises it again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable flag is 0, all three masks are 1, the serial output is 0, no latch is pending, irq_o is 0 and irq_vec_o is 0x0000.
- R2: Priority from highest to lowest is: non-maskable, edge source, high level source, low level source, general request. Only the highest active request drives irq_vec_o and irq_ext_o.
- R3: The vectors are 0x0024 for the non-maskable source, 0x003C for the edge source, 0x0034 for the high level source and 0x002C for the low level source. irq_vec_o is 0x0000 when no request is active or when the general request wins.
- R4: A rising edge on nmi_i latches a pending request. That request is presented regardless of the enable flag and the masks, and it is cleared by an acknowledge that it wins.
- R5: mask_wdata_i[2], [1] and [0] mask the edge, high level and low level sources, and a 1 blocks the source. They load only on a write with mask_wdata_i[3]=1. Otherwise the masks keep their value.
- R6: ser_out_o loads mask_wdata_i[7] only on a write with mask_wdata_i[6]=1.
- R7: A rising edge on edge_req_i sets a latch that stays pending whatever its mask is. The latch clears on an acknowledge that it wins, or on a write with mask_wdata_i[4]=1. A held-high input does not set the latch again.
- R8: The high and low level sources request only while their inputs are high. They are not latched.
- R9: ie_set_i sets the enable flag. ie_clr_i or ack_i clears it, and clearing wins over setting. While the flag is 0, only the non-maskable source can request.
- R10: status_o is {ser_in_i, edge latch, lvl_hi_i, lvl_lo_i, enable flag, mask[2:0]}, from bit 7 down to bit 0.
- R11: The general request wins only when the enable flag is 1 and no vectored source is requesting. While it wins, irq_o and irq_ext_o are 1 and irq_vec_o is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable source, rising-edge latched |
| edge_req_i | input | 1 | Maskable source, rising-edge latched |
| lvl_hi_i | input | 1 | Maskable level source, higher rank |
| lvl_lo_i | input | 1 | Maskable level source, lower rank |
| gen_req_i | input | 1 | General request without a vector |
| ie_set_i | input | 1 | Sets the enable flag |
| ie_clr_i | input | 1 | Clears the enable flag |
| ack_i | input | 1 | Acknowledges the presented request |
| mask_wr_i | input | 1 | Write strobe for mask_wdata_i |
| mask_wdata_i | input | 8 | Mask-write byte |
| ser_in_i | input | 1 | Serial input bit reported in the status byte |
| irq_o | output | 1 | A request is presented |
| irq_ext_o | output | 1 | The presented request is the general one |
| irq_vec_o | output | 16 | Restart address of the presented request |
| status_o | output | 8 | Status byte |
| ser_out_o | output | 1 | Serial output latch |

## Verification
The assertions assume that every input is synchronous to the clock. They also assume the edge input cannot rise in the same cycle as a latch-clear write unless it is high in that cycle, so the clear property only looks at cycles where the input is low. The stimulus changes inputs one time unit after the rising edge and samples one time unit after the following edge. It holds the latched inputs high across several rows, so a held level is never counted as a new edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned NMASK = 3;
  localparam int unsigned VEC_W = 16;
  localparam int unsigned BYTE_W = 8;

  // Source ranks, 0 is the most urgent.
  localparam int unsigned IDX_NMI  = 0;
  localparam int unsigned IDX_EDGE = 1;
  localparam int unsigned IDX_GEN  = NSRC - 1;

  // Mask-write byte fields.
  localparam int unsigned WB_SER_DATA = 7;
  localparam int unsigned WB_SER_EN   = 6;
  localparam int unsigned WB_EDGE_CLR = 4;
  localparam int unsigned WB_MASK_EN  = 3;

  // Restart slot in steps of four bytes: slot*4 is the vector.
  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
    logic [VEC_W-1:0] slot;
    case (idx)
      0:       slot = VEC_W'(9);
      1:       slot = VEC_W'(15);
      2:       slot = VEC_W'(13);
      3:       slot = VEC_W'(11);
      default: slot = '0;
    endcase
    return slot << 2;
  endfunction
endpackage

// File: rtl/irqc_sync_rst.sv
module irqc_sync_rst (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, pend_d, rise;

  assign rise = din_i & ~prev_q;

  // A new edge wins over a clear in the same cycle.
  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (rise)  pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= din_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_ctl_regs.sv
module irqc_ctl_regs
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              ack_i,
  output logic [NMASK-1:0]  mask_o,
  output logic              ie_o,
  output logic              ser_out_o,
  output logic              edge_clr_o
);
  logic [NMASK-1:0] mask_q, mask_d;
  logic             mask_en;
  logic             ie_q, ie_d;
  logic             ser_q, ser_d, ser_en;

  assign mask_en    = wr_i & wdata_i[WB_MASK_EN];
  assign ser_en     = wr_i & wdata_i[WB_SER_EN];
  assign edge_clr_o = wr_i & wdata_i[WB_EDGE_CLR];

  always_comb begin
    mask_d = wdata_i[NMASK-1:0];
    ser_d  = wdata_i[WB_SER_DATA];
    ie_d   = ie_q;
    if (ie_set_i)           ie_d = 1'b1;
    if (ie_clr_i || ack_i)  ie_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
      ser_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (ser_en)  ser_q  <= ser_d;
      ie_q <= ie_d;
    end
  end

  assign mask_o    = mask_q;
  assign ie_o      = ie_q;
  assign ser_out_o = ser_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  output logic [NSRC-1:0]  grant_o,
  output logic             any_o,
  output logic             ext_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NSRC:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_rank
    assign grant_o[i]   = req_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req_i[i];
  end

  always_comb begin
    vec_o = '0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      if (grant_o[i]) vec_o = vec_o | vec_of(i);
    end
  end

  assign any_o = blocked[NSRC];
  assign ext_o = grant_o[IDX_GEN];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              edge_req_i,
  input  logic              lvl_hi_i,
  input  logic              lvl_lo_i,
  input  logic              gen_req_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              ack_i,
  input  logic              mask_wr_i,
  input  logic [BYTE_W-1:0] mask_wdata_i,
  input  logic              ser_in_i,
  output logic              irq_o,
  output logic              irq_ext_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              ser_out_o
);
  logic             rst_sync_n;
  logic [NMASK-1:0] mask;
  logic             ie;
  logic             edge_clr_wr;
  logic             nmi_pend, edge_pend;
  logic             nmi_clr, edge_clr;
  logic [NSRC-1:0]  req, grant;
  logic [NMASK-1:0] msrc;
  logic             wdata_unused;

  assign wdata_unused = mask_wdata_i[5];

  irqc_sync_rst u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  irqc_ctl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_i       (mask_wr_i),
    .wdata_i    (mask_wdata_i),
    .ie_set_i   (ie_set_i),
    .ie_clr_i   (ie_clr_i),
    .ack_i      (ack_i),
    .mask_o     (mask),
    .ie_o       (ie),
    .ser_out_o  (ser_out_o),
    .edge_clr_o (edge_clr_wr)
  );

  assign nmi_clr  = ack_i & grant[IDX_NMI];
  assign edge_clr = (ack_i & grant[IDX_EDGE]) | edge_clr_wr;

  irqc_edge_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .din_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  irqc_edge_latch u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .din_i  (edge_req_i),
    .clr_i  (edge_clr),
    .pend_o (edge_pend)
  );

  // Maskable vectored sources, most urgent first; mask bit NMASK-1-m gates source m.
  assign msrc = {lvl_lo_i, lvl_hi_i, edge_pend};

  assign req[IDX_NMI] = nmi_pend;
  for (genvar m = 0; m < NMASK; m++) begin : g_mreq
    assign req[IDX_EDGE+m] = msrc[m] & ~mask[NMASK-1-m] & ie;
  end
  assign req[IDX_GEN] = gen_req_i & ie;

  irqc_prio u_prio (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (irq_o),
    .ext_o   (irq_ext_o),
    .vec_o   (irq_vec_o)
  );

  assign status_o = {ser_in_i, msrc[0], msrc[1], msrc[2], ie, mask};
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ie_set_i,
  input logic              ie_clr_i,
  input logic              ack_i,
  input logic              mask_wr_i,
  input logic [BYTE_W-1:0] mask_wdata_i,
  input logic              edge_req_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  irq_vec_o,
  input logic [BYTE_W-1:0] status_o,
  input logic              ser_out_o,
  input logic [NSRC-1:0]   grant_i
);
  p_one_winner_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  p_disabled_only_nmi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !status_o[3]) |-> (irq_vec_o == 16'h0024));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && mask_wdata_i[WB_MASK_EN]) |=> $stable(status_o[2:0]));

  p_ser_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask_wr_i && mask_wdata_i[WB_SER_EN]) |=> $stable(ser_out_o));

  p_edge_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_wdata_i[WB_EDGE_CLR] && !edge_req_i) |=> !status_o[6]);

  p_ie_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_clr_i || ack_i) |=> !status_o[3]);

  p_ie_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_set_i && !ie_clr_i && !ack_i) |=> status_o[3]);
endmodule

bind prio_irq_ctrl irqc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_sync_n),
  .ie_set_i     (ie_set_i),
  .ie_clr_i     (ie_clr_i),
  .ack_i        (ack_i),
  .mask_wr_i    (mask_wr_i),
  .mask_wdata_i (mask_wdata_i),
  .edge_req_i   (edge_req_i),
  .irq_o        (irq_o),
  .irq_vec_o    (irq_vec_o),
  .status_o     (status_o),
  .ser_out_o    (ser_out_o),
  .grant_i      (grant)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 1'b0, edg = 1'b0, hi = 1'b0, lo = 1'b0, gen = 1'b0;
  logic iset = 1'b0, iclr = 1'b0, ack = 1'b0, wr = 1'b0, si = 1'b0;
  logic [7:0] wd = 8'h00;
  logic irq, ext, so;
  logic [15:0] vec;
  logic [7:0] st;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .edge_req_i(edg),
    .lvl_hi_i(hi), .lvl_lo_i(lo), .gen_req_i(gen), .ie_set_i(iset),
    .ie_clr_i(iclr), .ack_i(ack), .mask_wr_i(wr), .mask_wdata_i(wd),
    .ser_in_i(si), .irq_o(irq), .irq_ext_o(ext), .irq_vec_o(vec),
    .status_o(st), .ser_out_o(so)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic n, e, h, l, g, s, c, a, w;
    logic [7:0] wd;
    logic si;
    logic x_irq, x_ext;
    logic [15:0] x_vec;
    logic [7:0] x_st;
    logic x_so;
  } row_t;

  localparam logic Z = 1'b0;
  localparam logic H = 1'b1;
  localparam int NROW = 23;

  // Rows apply in order; each row's outputs are sampled one edge later.
  localparam row_t TBL [NROW] = '{
    '{4'd5,  Z,Z,Z,Z,Z, Z,Z,Z,H, 8'h08, Z, Z,Z,16'h0000, 8'h00, Z}, // R5 masks cleared
    '{4'd9,  Z,Z,Z,Z,Z, H,Z,Z,Z, 8'h00, Z, Z,Z,16'h0000, 8'h08, Z}, // R9 enable
    '{4'd8,  Z,Z,Z,H,Z, Z,Z,Z,Z, 8'h00, Z, H,Z,16'h002C, 8'h18, Z}, // R8 low level
    '{4'd2,  Z,Z,H,H,Z, Z,Z,Z,Z, 8'h00, Z, H,Z,16'h0034, 8'h38, Z}, // R2 high over low
    '{4'd7,  Z,H,H,H,Z, Z,Z,Z,Z, 8'h00, Z, H,Z,16'h003C, 8'h78, Z}, // R7 edge latched
    '{4'd2,  Z,H,H,H,H, Z,Z,Z,Z, 8'h00, Z, H,Z,16'h003C, 8'h78, Z}, // R2 general loses
    '{4'd4,  H,H,H,H,H, Z,Z,Z,Z, 8'h00, Z, H,Z,16'h0024, 8'h78, Z}, // R4 nmi wins all
    '{4'd4,  H,H,H,H,H, Z,Z,H,Z, 8'h00, Z, Z,Z,16'h0000, 8'h70, Z}, // R4 ack clears nmi, ie
    '{4'd9,  H,H,H,H,H, H,Z,Z,Z, 8'h00, Z, H,Z,16'h003C, 8'h78, Z}, // R9 re-enable
    '{4'd7,  H,H,H,H,H, Z,Z,H,Z, 8'h00, Z, Z,Z,16'h0000, 8'h30, Z}, // R7 ack clears edge
    '{4'd7,  H,H,H,H,H, H,Z,Z,Z, 8'h00, Z, H,Z,16'h0034, 8'h38, Z}, // R7 held high no relatch
    '{4'd5,  H,H,H,H,H, Z,Z,Z,H, 8'h02, Z, H,Z,16'h0034, 8'h38, Z}, // R5 no mask-enable
    '{4'd5,  H,H,H,H,H, Z,Z,Z,H, 8'h0A, Z, H,Z,16'h002C, 8'h3A, Z}, // R5 high masked
    '{4'd11, Z,Z,Z,Z,H, Z,Z,Z,Z, 8'h00, Z, H,H,16'h0000, 8'h0A, Z}, // R11 general wins
    '{4'd6,  Z,Z,Z,Z,H, Z,Z,Z,H, 8'hC8, Z, H,H,16'h0000, 8'h08, H}, // R6 serial load 1
    '{4'd6,  Z,Z,Z,Z,Z, Z,Z,Z,H, 8'h00, Z, Z,Z,16'h0000, 8'h08, H}, // R6 serial held
    '{4'd10, Z,Z,Z,Z,Z, Z,Z,Z,Z, 8'h00, H, Z,Z,16'h0000, 8'h88, H}, // R10 serial in bit
    '{4'd6,  Z,Z,Z,Z,Z, Z,Z,Z,H, 8'h40, Z, Z,Z,16'h0000, 8'h08, Z}, // R6 serial load 0
    '{4'd9,  Z,Z,Z,Z,Z, H,H,Z,Z, 8'h00, Z, Z,Z,16'h0000, 8'h00, Z}, // R9 clear wins
    '{4'd7,  Z,H,Z,Z,Z, Z,Z,Z,Z, 8'h00, Z, Z,Z,16'h0000, 8'h40, Z}, // R7 pending while off
    '{4'd7,  Z,H,Z,Z,Z, Z,Z,Z,H, 8'h10, Z, Z,Z,16'h0000, 8'h00, Z}, // R7 write clear
    '{4'd4,  H,Z,Z,Z,Z, Z,Z,Z,H, 8'h0F, Z, H,Z,16'h0024, 8'h07, Z}, // R4 nmi while disabled
    '{4'd4,  H,Z,Z,Z,Z, Z,Z,H,Z, 8'h00, Z, Z,Z,16'h0000, 8'h07, Z}  // R4 ack clears nmi
  };

  task automatic check(input string tag, input logic [26:0] act, input logic [26:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual irq/ext/vec/st/so=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] outs();
    return {irq, ext, vec, st, so};
  endfunction

  task automatic drive_idle();
    {nmi, edg, hi, lo, gen, iset, iclr, ack, wr, si} = '0;
    wd = 8'h00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset", outs(), {1'b0, 1'b0, 16'h0000, 8'h07, 1'b0});

    for (int i = 0; i < NROW; i++) begin
      nmi = TBL[i].n; edg = TBL[i].e; hi = TBL[i].h; lo = TBL[i].l;
      gen = TBL[i].g; iset = TBL[i].s; iclr = TBL[i].c; ack = TBL[i].a;
      wr = TBL[i].w; wd = TBL[i].wd; si = TBL[i].si;
      @(posedge clk); #1;
      check($sformatf("R%0d row %0d", TBL[i].rq, i), outs(),
            {TBL[i].x_irq, TBL[i].x_ext, TBL[i].x_vec, TBL[i].x_st, TBL[i].x_so});
    end

    // R9 acknowledge beats a set strobe in the same cycle
    drive_idle(); iset = 1'b1; ack = 1'b1;
    @(posedge clk); #1;
    check("R9 ack over set", outs(), {1'b0, 1'b0, 16'h0000, 8'h07, 1'b0});

    // R3 edge source vector alone while enabled and unmasked
    drive_idle(); iset = 1'b1; wr = 1'b1; wd = 8'h08;
    @(posedge clk); #1;
    drive_idle(); edg = 1'b1;
    @(posedge clk); #1;
    check("R3 edge vector", outs(), {1'b1, 1'b0, 16'h003C, 8'h48, 1'b0});

    // R1 reset in mid-run restores the reset state
    drive_idle(); wr = 1'b1; wd = 8'hC8;
    @(posedge clk); #1;
    drive_idle();
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", outs(), {1'b0, 1'b0, 16'h0000, 8'h07, 1'b0});
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after re-release", outs(), {1'b0, 1'b0, 16'h0000, 8'h07, 1'b0});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule